// File: doc/BRIEF.md
# UART Receive Holding Queue with Error Status

This block is the buffer stage between a UART receiver's shift register and the CPU. Each time the receiver finishes assembling a character, it raises a one-cycle strobe with the data byte and three error flags: parity, framing and line break. The block queues the character and its flags in a three-entry holding FIFO. When all three entries are in use, the block keeps one more character in a shift-stage slot. Four characters can therefore wait between the serial line and the CPU. The CPU reads the oldest character through a read strobe. The byte appears on a registered data port, and the entry is removed.

The block drives several outputs. It reports ready (at least one character held) and full (every holding entry in use). It keeps an overrun flag that stays set until cleared. It reports the error status in one of two modes:
- Per-character mode shows the flags of the oldest character only.
- Block mode shows the OR of the flags of every character accepted since the last error-reset command.

An interrupt line follows either ready or full. A DMA request line follows either ready or an external transmitter-ready input. An optional receiver-controlled RTS output is raised by command. In automatic mode, RTS drops when an overrun happens and comes back once the shift-stage slot is free again.

Top module: `uart_rxq`

## Requirements
- R1: `rx_rdy` is 1 exactly when the holding FIFO has at least one character; the shift-stage slot alone cannot make it 1.
- R2: `rx_full` is 1 exactly when all three holding entries are occupied.
- R3: Characters are read out oldest first. A read with `rd_en`=1 loads the oldest byte onto `rd_data` at the same clock edge that removes it. A read while the FIFO is empty leaves `rd_data` and the occupancy unchanged.
- R4: A character that arrives while all three entries are full waits in the shift-stage slot. At the next read it moves into the FIFO, behind the characters already queued. Up to four characters are held in total.
- R5: A character that arrives while three entries and the shift-stage slot are all occupied is discarded. `ovr` is set at that edge and stays 1 until an error-reset or receiver-reset command.
- R6: With `cfg_block`=0, the outputs `stat_perr`, `stat_ferr` and `stat_brk` equal the parity, framing and break flags stored with the oldest held character. All three are 0 when the FIFO is empty.
- R7: With `cfg_block`=1, each status output is the OR of that flag over every character accepted (queued or parked, not discarded) since the last error-reset command.
- R8: `cmd_err_rst` clears `ovr` and the accumulated block-mode flags. It takes priority over an overrun in the same cycle and leaves the queued data untouched.
- R9: `cmd_rx_rst` empties the FIFO and the shift-stage slot and clears `rx_rdy`, `rx_full` and `ovr`. An arriving character in that same cycle is dropped.
- R10: `irq` follows `rx_rdy` when `cfg_irq_full`=0 and follows `rx_full` when `cfg_irq_full`=1.
- R11: `dma_req` follows `rx_rdy` when `cfg_dma_tx`=0 and follows `tx_ready` when `cfg_dma_tx`=1.
- R12: `rts` is 0 after reset and is set by `cmd_rts_set`. With `cfg_rts_auto`=1, an overrun drops `rts` at that edge. `rts` is then raised again one edge after the shift-stage slot becomes empty. With `cfg_rts_auto`=0, an overrun leaves `rts` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a character has been assembled |
| rx_data | input | 8 | Assembled character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| rd_en | input | 1 | CPU read strobe, pops the oldest character |
| cmd_err_rst | input | 1 | Clear overrun and accumulated flags |
| cmd_rx_rst | input | 1 | Empty the receive buffer and clear overrun |
| cmd_rts_set | input | 1 | Raise RTS |
| cfg_block | input | 1 | 0 = per-character status, 1 = accumulated status |
| cfg_irq_full | input | 1 | Interrupt source: 0 = ready, 1 = full |
| cfg_dma_tx | input | 1 | DMA source: 0 = ready, 1 = tx_ready |
| cfg_rts_auto | input | 1 | Enable automatic RTS drop and restore |
| tx_ready | input | 1 | Transmitter-ready indication used for DMA routing |
| rd_data | output | 8 | Byte returned by the last successful read |
| rx_rdy | output | 1 | At least one character held |
| rx_full | output | 1 | All three holding entries occupied |
| stat_perr | output | 1 | Parity error status |
| stat_ferr | output | 1 | Framing error status |
| stat_brk | output | 1 | Break status |
| ovr | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receiver interrupt request |
| dma_req | output | 1 | DMA request |
| rts | output | 1 | Request-to-send to the far end |

## Verification
All state lives in registers, and the status, interrupt, DMA and ready outputs are decoded directly from that state. The effect of a strobe sampled at one rising edge is therefore visible right after that edge. This holds for reads, incoming characters and commands. The one exception is the automatic RTS restore, which arrives one further edge after the shift-stage slot empties. The bench drives each stimulus for exactly one edge, advances a queue model by the same single step, and compares every output at the following falling edge. The RTS restore is checked through the model's record of the shift-stage state from the previous step.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic perr;
        logic ferr;
        logic brk;
    } rx_flg_t;

    typedef struct packed {
        rx_flg_t             flg;
        logic [DATA_W-1:0]   data;
    } rx_ent_t;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  rx_ent_t           in_ent,
    input  logic              rd_en,
    input  logic              flush,
    output logic [CW-1:0]     cnt_o,
    output rx_ent_t           top_o,
    output logic              park_vld_o,
    output logic              accept_o,
    output logic              lost_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        rx_ent_t [DEPTH-1:0] mem;
        rx_ent_t             park;
        logic                park_vld;
        logic [CW-1:0]       cnt;
        logic [DATA_W-1:0]   rdd;
    } store_t;

    store_t q, d;
    logic   accept, lost;

    always_comb begin
        d      = q;
        accept = 1'b0;
        lost   = 1'b0;

        // pop the oldest entry
        if (rd_en && q.cnt != '0) begin
            d.rdd = q.mem[0].data;
            for (int i = 0; i < DEPTH - 1; i++) begin
                d.mem[i] = q.mem[i + 1];
            end
            d.mem[DEPTH-1] = '0;
            d.cnt          = q.cnt - 1'b1;
        end

        // parked character moves into the freed slot
        if (d.park_vld && d.cnt != FULL_CNT) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == d.cnt) begin
                    d.mem[i] = d.park;
                end
            end
            d.cnt      = d.cnt + 1'b1;
            d.park_vld = 1'b0;
        end

        // newly assembled character
        if (in_vld) begin
            if (!d.park_vld && d.cnt != FULL_CNT) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == d.cnt) begin
                        d.mem[i] = in_ent;
                    end
                end
                d.cnt  = d.cnt + 1'b1;
                accept = 1'b1;
            end else if (!d.park_vld) begin
                d.park     = in_ent;
                d.park_vld = 1'b1;
                accept     = 1'b1;
            end else begin
                lost = 1'b1;
            end
        end

        if (flush) begin
            d.mem      = '0;
            d.park     = '0;
            d.park_vld = 1'b0;
            d.cnt      = '0;
            d.rdd      = q.rdd;
            accept     = 1'b0;
            lost       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cnt_o      = q.cnt;
    assign top_o      = q.mem[0];
    assign park_vld_o = q.park_vld;
    assign accept_o   = accept;
    assign lost_o     = lost;
    assign rd_data_o  = q.rdd;
endmodule

// File: rtl/uart_rxq_flags.sv
module uart_rxq_flags
    import uart_rxq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    accept,
    input  rx_flg_t in_flg,
    input  logic    lost,
    input  logic    park_vld,
    input  logic    cmd_err_rst,
    input  logic    cmd_rx_rst,
    input  logic    cmd_rts_set,
    input  logic    cfg_rts_auto,
    output rx_flg_t acc_o,
    output logic    ovr_o,
    output logic    rts_o
);
    typedef struct packed {
        rx_flg_t acc;
        logic    ovr;
        logic    rts;
        logic    dropped;
    } flg_st_t;

    flg_st_t q, d;

    always_comb begin
        d = q;

        if (accept) begin
            d.acc = q.acc | in_flg;
        end
        if (lost) begin
            d.ovr = 1'b1;
        end
        if (cmd_err_rst) begin
            d.ovr = 1'b0;
            d.acc = '0;
        end
        if (cmd_rx_rst) begin
            d.ovr = 1'b0;
        end

        if (cmd_rts_set) begin
            d.rts     = 1'b1;
            d.dropped = 1'b0;
        end
        if (q.dropped && !park_vld) begin
            d.rts     = 1'b1;
            d.dropped = 1'b0;
        end
        if (cfg_rts_auto && lost) begin
            d.rts     = 1'b0;
            d.dropped = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_o = q.acc;
    assign ovr_o = q.ovr;
    assign rts_o = q.rts;
endmodule

// File: rtl/uart_rxq_route.sv
module uart_rxq_route
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] cnt,
    input  rx_flg_t       top_flg,
    input  rx_flg_t       acc_flg,
    input  logic          cfg_block,
    input  logic          cfg_irq_full,
    input  logic          cfg_dma_tx,
    input  logic          tx_ready,
    output logic          rdy_o,
    output logic          full_o,
    output rx_flg_t       stat_o,
    output logic          irq_o,
    output logic          dma_o
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    always_comb begin
        rdy_o  = (cnt != '0);
        full_o = (cnt == FULL_CNT);
        if (cfg_block) begin
            stat_o = acc_flg;
        end else if (rdy_o) begin
            stat_o = top_flg;
        end else begin
            stat_o = '0;
        end
        irq_o = cfg_irq_full ? full_o : rdy_o;
        dma_o = cfg_dma_tx ? tx_ready : rdy_o;
    end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              rd_en,
    input  logic              cmd_err_rst,
    input  logic              cmd_rx_rst,
    input  logic              cmd_rts_set,
    input  logic              cfg_block,
    input  logic              cfg_irq_full,
    input  logic              cfg_dma_tx,
    input  logic              cfg_rts_auto,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_rdy,
    output logic              rx_full,
    output logic              stat_perr,
    output logic              stat_ferr,
    output logic              stat_brk,
    output logic              ovr,
    output logic              irq,
    output logic              dma_req,
    output logic              rts
);
    rx_ent_t       in_ent, top_ent;
    rx_flg_t       acc_flg, stat;
    logic [CW-1:0] cnt;
    logic          park_vld, accept, lost;

    assign in_ent.data     = rx_data;
    assign in_ent.flg.perr = rx_perr;
    assign in_ent.flg.ferr = rx_ferr;
    assign in_ent.flg.brk  = rx_brk;

    uart_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (rx_valid),
        .in_ent     (in_ent),
        .rd_en      (rd_en),
        .flush      (cmd_rx_rst),
        .cnt_o      (cnt),
        .top_o      (top_ent),
        .park_vld_o (park_vld),
        .accept_o   (accept),
        .lost_o     (lost),
        .rd_data_o  (rd_data)
    );

    uart_rxq_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .in_flg       (in_ent.flg),
        .lost         (lost),
        .park_vld     (park_vld),
        .cmd_err_rst  (cmd_err_rst),
        .cmd_rx_rst   (cmd_rx_rst),
        .cmd_rts_set  (cmd_rts_set),
        .cfg_rts_auto (cfg_rts_auto),
        .acc_o        (acc_flg),
        .ovr_o        (ovr),
        .rts_o        (rts)
    );

    uart_rxq_route #(.DEPTH(DEPTH)) u_route (
        .cnt          (cnt),
        .top_flg      (top_ent.flg),
        .acc_flg      (acc_flg),
        .cfg_block    (cfg_block),
        .cfg_irq_full (cfg_irq_full),
        .cfg_dma_tx   (cfg_dma_tx),
        .tx_ready     (tx_ready),
        .rdy_o        (rx_rdy),
        .full_o       (rx_full),
        .stat_o       (stat),
        .irq_o        (irq),
        .dma_o        (dma_req)
    );

    assign stat_perr = stat.perr;
    assign stat_ferr = stat.ferr;
    assign stat_brk  = stat.brk;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_rdy,
    input logic       rx_full,
    input logic       ovr,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       cmd_err_rst,
    input logic       cmd_rx_rst,
    input logic       rts,
    input logic       cfg_rts_auto
);
    // R2
    full_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_rdy);

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !cmd_err_rst && !cmd_rx_rst |=> ovr);

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_rst |=> !ovr);

    // R9
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rx_rst |=> !rx_rdy && !rx_full && !ovr);

    // R3
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rx_rdy |=> $stable(rd_data));

    // R12
    rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) && $past(cfg_rts_auto) |-> !rts);
endmodule

bind uart_rxq uart_rxq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_rdy       (rx_rdy),
    .rx_full      (rx_full),
    .ovr          (ovr),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .cmd_err_rst  (cmd_err_rst),
    .cmd_rx_rst   (cmd_rx_rst),
    .rts          (rts),
    .cfg_rts_auto (cfg_rts_auto)
);

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
    logic [7:0] rx_data = '0;
    logic       rd_en = 0, cmd_err_rst = 0, cmd_rx_rst = 0, cmd_rts_set = 0;
    logic       cfg_block = 0, cfg_irq_full = 0, cfg_dma_tx = 0, cfg_rts_auto = 0;
    logic       tx_ready = 0;
    logic [7:0] rd_data;
    logic       rx_rdy, rx_full, stat_perr, stat_ferr, stat_brk, ovr, irq, dma_req, rts;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // queue model: index 0 is oldest, up to 4 held (3 entries + shift-stage slot)
    logic [7:0] m_data [4];
    logic [2:0] m_flg  [4];   // {perr, ferr, brk}
    int         m_n = 0;
    logic [7:0] m_rdd = '0;
    logic       m_ovr = 0, m_rts = 0, m_drop = 0;
    logic [2:0] m_acc = '0;

    always #4 clk = ~clk;

    uart_rxq u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rd_en(rd_en),
        .cmd_err_rst(cmd_err_rst), .cmd_rx_rst(cmd_rx_rst), .cmd_rts_set(cmd_rts_set),
        .cfg_block(cfg_block), .cfg_irq_full(cfg_irq_full), .cfg_dma_tx(cfg_dma_tx),
        .cfg_rts_auto(cfg_rts_auto), .tx_ready(tx_ready), .rd_data(rd_data),
        .rx_rdy(rx_rdy), .rx_full(rx_full), .stat_perr(stat_perr), .stat_ferr(stat_ferr),
        .stat_brk(stat_brk), .ovr(ovr), .irq(irq), .dma_req(dma_req), .rts(rts)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [2:0] e_stat;
        logic       e_rdy, e_full;
        e_rdy  = (m_n > 0);
        e_full = (m_n >= 3);
        if (cfg_block) e_stat = m_acc;
        else           e_stat = e_rdy ? m_flg[0] : 3'b000;
        chk("R1 rx_rdy", rx_rdy, e_rdy);
        chk("R2 rx_full", rx_full, e_full);
        chk("R3 rd_data", rd_data, m_rdd);
        chk("R5 ovr", ovr, m_ovr);
        chk(cfg_block ? "R7 block status" : "R6 char status",
            {stat_perr, stat_ferr, stat_brk}, e_stat);
        chk("R10 irq", irq, cfg_irq_full ? e_full : e_rdy);
        chk("R11 dma_req", dma_req, cfg_dma_tx ? tx_ready : e_rdy);
        chk("R12 rts", rts, m_rts);
    endtask

    // one clock of stimulus, model step, then compare at the falling edge
    task automatic cyc(input logic v, input logic [7:0] d, input logic [2:0] f,
                       input logic rd, input logic er, input logic rr, input logic rs);
        logic sr_before, lost;
        rx_valid = v; rx_data = d; {rx_perr, rx_ferr, rx_brk} = f;
        rd_en = rd; cmd_err_rst = er; cmd_rx_rst = rr; cmd_rts_set = rs;
        @(posedge clk);
        sr_before = (m_n == 4);
        lost = 0;
        if (rr) begin
            m_n = 0;
        end else begin
            if (rd && m_n > 0) begin
                m_rdd = m_data[0];
                for (int i = 0; i < 3; i++) begin
                    m_data[i] = m_data[i+1];
                    m_flg[i]  = m_flg[i+1];
                end
                m_n--;
            end
            if (v) begin
                if (m_n < 4) begin
                    m_data[m_n] = d; m_flg[m_n] = f; m_n++;
                    m_acc = m_acc | f;
                end else begin
                    lost = 1;
                    m_ovr = 1;
                end
            end
        end
        if (er) begin m_ovr = 0; m_acc = '0; end
        if (rr) m_ovr = 0;
        if (rs) begin m_rts = 1; m_drop = 0; end
        if (m_drop && !sr_before) begin m_rts = 1; m_drop = 0; end
        if (cfg_rts_auto && lost) begin m_rts = 0; m_drop = 1; end
        @(negedge clk);
        rx_valid = 0; rd_en = 0; cmd_err_rst = 0; cmd_rx_rst = 0; cmd_rts_set = 0;
        check_all();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_data[i] = '0; m_flg[i] = '0; end
        repeat (3) @(negedge clk);
        // reset state (R1 R2 R5 R12)
        check_all();
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // R4: fourth char parks, R5 fifth char lost, drain order R3
        cyc(0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 5; i++) cyc(1, 8'hA0 + 8'(i), 3'(i + 1), 0, 0, 0, 0);
        chk("R5 fifth char lost", ovr, 1);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R3 empty read keeps last byte", rd_data, 8'hA3);
        cyc(0, 0, 0, 0, 1, 0, 0);

        // configuration sweep x fill level x simultaneous read/write
        for (int cfg = 0; cfg < 16; cfg++) begin
            cfg_block = cfg[0]; cfg_irq_full = cfg[1];
            cfg_dma_tx = cfg[2]; cfg_rts_auto = cfg[3];
            for (int n = 0; n <= 6; n++) begin
                tx_ready = n[0];
                cyc(0, 0, 0, 0, 1, 1, 1);            // R9 R8 R12
                for (int i = 0; i < n; i++)
                    cyc(1, 8'(16 * n + i + cfg), 3'(i + n + cfg), 0, 0, 0, 0);
                cyc(1, 8'hE0 + 8'(n), 3'(n), 1, 0, 0, 0);   // read and write together
                if (n == 4) cyc(0, 0, 0, 0, 1, 0, 0);       // R8 mid-stream
                for (int i = 0; i <= n + 1; i++) cyc(0, 0, 0, 1, 0, 0, 0);
                cyc(0, 0, 0, 0, 0, 0, 0);            // R12 restore settles
            end
        end

        // R9: flush with a full buffer and a simultaneous arrival
        cfg_block = 0;
        for (int i = 0; i < 5; i++) cyc(1, 8'(i), 3'b111, 0, 0, 0, 0);
        cyc(1, 8'h55, 3'b001, 0, 0, 1, 0);
        chk("R9 flush empties", rx_rdy, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule